// File: doc/BRIEF.md
# Peripheral-Paced DMA Channel with Request/Acknowledge Handshake

This block runs a single DMA channel whose pace is set by an off-chip peripheral. The peripheral raises a request pin, and the channel then issues one byte or word access on a simple bus-master port. While that access's strobe is active, the channel drives an acknowledge pin. A shared end-of-block pin has two uses, chosen by configuration:
- The channel drives it as a terminal-count marker on the last access.
- The peripheral drives it to cut the block short.

Software fills two buffer descriptors, each holding a start address and a byte count, and then pulses `start`. The request pin can be set to level or edge sensing and to either polarity. The acknowledge and end-of-block pins also have a programmable polarity. The end-of-block pin is split into `tc_out`, `tc_oe` and `deot_in`; the pad combines them outside the block.

When a block finishes, the channel records two flags: whether the programmed count was used up, and whether the peripheral ended the block. It pulses `irq` for one cycle. If rollover is enabled, it re-arms at once from the other descriptor.

Top module: `xhs_dma_chan`

## Requirements
- R1: After reset `bus_req`, `irq`, `stat_limit`, `stat_eot` and `active_desc` are 0, and `dack` sits at its inactive level (the inverse of `cfg_ack_high`).
- R2: In level mode (`cfg_edge`=0) the request counts as active when `dreq` equals `cfg_req_high`. No bus request is raised while the request is inactive. The request is sampled either while the channel waits or in the last strobe cycle of a non-final access. A request held across accesses therefore raises `bus_req` in the cycle right after `dack` releases.
- R3: In edge mode (`cfg_edge`=1) an access starts only on an inactive-to-active change of `dreq` seen inside the sampling window. A request that stays held yields no further access.
- R4: `bus_size` is 0 for a byte and 1 for a 32-bit word, following `cfg_word`. `bus_write` follows `cfg_write`. `bus_addr` starts at the descriptor address and advances by 1 or 4 per access. `bus_req`, with a stable address, holds until `bus_gnt`.
- R5: `dack` is active from the cycle after `bus_gnt` for `cfg_wait`+1 cycles and is never active together with `bus_req`. Its active level is `cfg_ack_high`.
- R6: The remaining count drops by 1 (byte) or 4 (word), saturating at 0. An access is final when the remaining count is no greater than that step. No access follows the final one.
- R7: With `cfg_tc_drive`=1, `tc_oe` is 1 and `tc_out` is at level `cfg_tc_high` during the `dack` cycles of the final access only. With `cfg_tc_drive`=0, `tc_oe` is 0.
- R8: With `cfg_tc_drive`=0, `deot_in` at level `cfg_tc_high` when a request is accepted makes that access the final one.
- R9: At block end `stat_limit` becomes 1 exactly when the remaining count reached 0, and `stat_eot` becomes 1 exactly when `deot_in` ended the block. `start` clears both, and they hold otherwise.
- R10: `irq` is a one-cycle pulse in the cycle after the last `dack` cycle of a block.
- R11: At block end with `cfg_rollover`=1, `active_desc` toggles and the channel reloads from the other descriptor without a new `start`. With `cfg_rollover`=0 it goes idle and `active_desc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_edge | input | 1 | 1: edge-sensed request, 0: level-sensed |
| cfg_req_high | input | 1 | Active level of `dreq` |
| cfg_ack_high | input | 1 | Active level of `dack` |
| cfg_tc_drive | input | 1 | 1: drive terminal count, 0: sense end-of-block input |
| cfg_tc_high | input | 1 | Active level of the end-of-block pin in both directions |
| cfg_word | input | 1 | 1: word accesses, 0: byte accesses |
| cfg_write | input | 1 | Access direction forwarded to `bus_write` |
| cfg_rollover | input | 1 | Re-arm from the other descriptor at block end |
| cfg_wait | input | WAIT_W | Extra strobe cycles per access |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 1 | Descriptor written |
| desc_addr | input | ADDR_W | Start address to store |
| desc_cnt | input | CNT_W | Byte count to store |
| start | input | 1 | Arm the channel from the active descriptor |
| dreq | input | 1 | Peripheral request |
| deot_in | input | 1 | End-of-block input from the peripheral |
| bus_gnt | input | 1 | Bus accepted the pending access |
| dack | output | 1 | Peripheral acknowledge |
| tc_out | output | 1 | Terminal-count output value |
| tc_oe | output | 1 | Output enable for the end-of-block pin |
| bus_req | output | 1 | Access request to the bus |
| bus_write | output | 1 | Access direction |
| bus_size | output | 1 | 0 byte, 1 word |
| bus_addr | output | ADDR_W | Access address |
| irq | output | 1 | Block-complete pulse |
| stat_limit | output | 1 | Count used up at last block end |
| stat_eot | output | 1 | Peripheral ended last block |
| active_desc | output | 1 | Descriptor currently in use |

## Verification
A corrupted remaining count shows up at the ports by the next access at the latest. Either the terminal-count marker lands on the wrong acknowledge window, or an access is requested after `irq`, or `irq` arrives early. A wrong sequencer state shows within one access: `bus_req` overlaps `dack`, or the strobe length differs from `cfg_wait`+1. A stale request-history bit shows as an extra access under a held edge-mode request, within one cycle of the window opening. Broken descriptor steering shows as a wrong `bus_addr` on the first access after rollover.

// File: rtl/xhs_pkg.sv
package xhs_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // channel not armed
    ST_WREQ = 2'd1,  // armed, waiting for a sampled request
    ST_BUS  = 2'd2,  // access requested, waiting for grant
    ST_ACK  = 2'd3   // strobe / acknowledge window
  } xhs_state_e;

  localparam int unsigned NUM_DESC = 2;

  // Pin compared against its programmed active level.
  function automatic logic pin_active(input logic pin, input logic high);
    return pin == high;
  endfunction

  // Internal active-high value mapped onto a pin of given polarity.
  function automatic logic pin_drive(input logic on, input logic high);
    return high ? on : ~on;
  endfunction

endpackage

// File: rtl/xhs_req_sense.sv
module xhs_req_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_pin,
  input  logic deot_pin,
  input  logic cfg_edge,
  input  logic cfg_req_high,
  input  logic cfg_tc_drive,
  input  logic cfg_tc_high,
  input  logic window,
  output logic req_hit,
  output logic eot_hit
);
  import xhs_pkg::*;

  logic req_now;
  logic req_prev;
  logic req_rise;

  assign req_now  = pin_active(dreq_pin, cfg_req_high);
  assign req_rise = req_now & ~req_prev;

  // History bit follows the pin every cycle, so an edge is judged
  // against the previous cycle regardless of the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= 1'b0;
    else        req_prev <= req_now;
  end

  assign req_hit = window & (cfg_edge ? req_rise : req_now);
  assign eot_hit = ~cfg_tc_drive & pin_active(deot_pin, cfg_tc_high);

endmodule

// File: rtl/xhs_desc_bank.sv
module xhs_desc_bank #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              flip,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              sel
);
  import xhs_pkg::*;

  logic [ADDR_W-1:0] ent_addr [NUM_DESC];
  logic [CNT_W-1:0]  ent_cnt  [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[g] <= '0;
        ent_cnt[g]  <= '0;
      end else if (wr_en && (wr_idx == 1'(g))) begin
        ent_addr[g] <= wr_addr;
        ent_cnt[g]  <= wr_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= 1'b0;
    else if (flip) sel <= ~sel;
  end

  assign cur_addr = ent_addr[sel];
  assign cur_cnt  = ent_cnt[sel];
  assign nxt_addr = ent_addr[~sel];
  assign nxt_cnt  = ent_cnt[~sel];

endmodule

// File: rtl/xhs_xfer_seq.sv
module xhs_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_word,
  input  logic              cfg_rollover,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [CNT_W-1:0]  nxt_cnt,
  input  logic              req_hit,
  input  logic              eot_hit,
  input  logic              bus_gnt,
  output logic              window,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              dack_on,
  output logic              last_on,
  output logic              xfer_end,
  output logic              blk_end,
  output logic              flip,
  output logic              irq,
  output logic              stat_limit,
  output logic              stat_eot
);
  import xhs_pkg::*;

  localparam logic [CNT_W-1:0] STEP_B = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_W = CNT_W'(4);

  // Bytes moved per access.
  function automatic logic [CNT_W-1:0] step_of(input logic word);
    return word ? STEP_W : STEP_B;
  endfunction

  // True when this access uses up what remains.
  function automatic logic is_final(input logic [CNT_W-1:0] left, input logic word);
    return left <= step_of(word);
  endfunction

  // Remaining count after one access, saturating at zero.
  function automatic logic [CNT_W-1:0] left_after(input logic [CNT_W-1:0] left,
                                                  input logic word);
    return is_final(left, word) ? '0 : left - step_of(word);
  endfunction

  xhs_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic [WAIT_W-1:0] wcnt;
  logic              last_q;
  logic              eot_q;
  logic [CNT_W-1:0]  cnt_left;
  logic [ADDR_W-1:0] addr_next;

  assign cnt_left  = left_after(cnt, cfg_word);
  assign addr_next = addr + ADDR_W'(step_of(cfg_word));

  assign bus_req  = (st == ST_BUS);
  assign bus_addr = addr;
  assign dack_on  = (st == ST_ACK);
  assign last_on  = dack_on & last_q;
  assign xfer_end = dack_on & (wcnt == '0);
  assign blk_end  = xfer_end & last_q;
  assign flip     = blk_end & cfg_rollover;
  // Request is looked at while waiting, or in the release cycle of a
  // non-final strobe so a held request chains without a gap.
  assign window   = (st == ST_WREQ) | (xfer_end & ~last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      addr       <= '0;
      wcnt       <= '0;
      last_q     <= 1'b0;
      eot_q      <= 1'b0;
      irq        <= 1'b0;
      stat_limit <= 1'b0;
      stat_eot   <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            cnt        <= cur_cnt;
            addr       <= cur_addr;
            stat_limit <= 1'b0;
            stat_eot   <= 1'b0;
            st         <= ST_WREQ;
          end
        end
        ST_WREQ: begin
          if (req_hit) begin
            last_q <= is_final(cnt, cfg_word) | eot_hit;
            eot_q  <= eot_hit;
            st     <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (bus_gnt) begin
            wcnt <= cfg_wait;
            st   <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - WAIT_W'(1);
          end else if (last_q) begin
            irq        <= 1'b1;
            stat_limit <= (cnt_left == '0);
            stat_eot   <= eot_q;
            last_q     <= 1'b0;
            eot_q      <= 1'b0;
            if (cfg_rollover) begin
              cnt  <= nxt_cnt;
              addr <= nxt_addr;
              st   <= ST_WREQ;
            end else begin
              cnt  <= cnt_left;
              addr <= addr_next;
              st   <= ST_IDLE;
            end
          end else begin
            cnt  <= cnt_left;
            addr <= addr_next;
            if (req_hit) begin
              last_q <= is_final(cnt_left, cfg_word) | eot_hit;
              eot_q  <= eot_hit;
              st     <= ST_BUS;
            end else begin
              st <= ST_WREQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xhs_dma_chan.sv
module xhs_dma_chan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_edge,
  input  logic              cfg_req_high,
  input  logic              cfg_ack_high,
  input  logic              cfg_tc_drive,
  input  logic              cfg_tc_high,
  input  logic              cfg_word,
  input  logic              cfg_write,
  input  logic              cfg_rollover,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              desc_we,
  input  logic              desc_idx,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [CNT_W-1:0]  desc_cnt,
  input  logic              start,
  input  logic              dreq,
  input  logic              deot_in,
  input  logic              bus_gnt,
  output logic              dack,
  output logic              tc_out,
  output logic              tc_oe,
  output logic              bus_req,
  output logic              bus_write,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              irq,
  output logic              stat_limit,
  output logic              stat_eot,
  output logic              active_desc
);
  import xhs_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              window;
  logic              req_hit;
  logic              eot_hit;
  logic              dack_on;
  logic              last_on;
  logic              xfer_end;
  logic              blk_end;
  logic              flip;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic [ADDR_W-1:0] nxt_addr;
  logic [CNT_W-1:0]  nxt_cnt;

  xhs_req_sense u_sense (
    .clk          (clk),
    .rst_n        (rst_n),
    .dreq_pin     (dreq),
    .deot_pin     (deot_in),
    .cfg_edge     (cfg_edge),
    .cfg_req_high (cfg_req_high),
    .cfg_tc_drive (cfg_tc_drive),
    .cfg_tc_high  (cfg_tc_high),
    .window       (window),
    .req_hit      (req_hit),
    .eot_hit      (eot_hit)
  );

  xhs_desc_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (desc_we),
    .wr_idx   (desc_idx),
    .wr_addr  (desc_addr),
    .wr_cnt   (desc_cnt),
    .flip     (flip),
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .nxt_addr (nxt_addr),
    .nxt_cnt  (nxt_cnt),
    .sel      (active_desc)
  );

  xhs_xfer_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_word     (cfg_word),
    .cfg_rollover (cfg_rollover),
    .cfg_wait     (cfg_wait),
    .cur_addr     (cur_addr),
    .cur_cnt      (cur_cnt),
    .nxt_addr     (nxt_addr),
    .nxt_cnt      (nxt_cnt),
    .req_hit      (req_hit),
    .eot_hit      (eot_hit),
    .bus_gnt      (bus_gnt),
    .window       (window),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .dack_on      (dack_on),
    .last_on      (last_on),
    .xfer_end     (xfer_end),
    .blk_end      (blk_end),
    .flip         (flip),
    .irq          (irq),
    .stat_limit   (stat_limit),
    .stat_eot     (stat_eot)
  );

  assign dack      = pin_drive(dack_on, cfg_ack_high);
  assign tc_out    = pin_drive(last_on, cfg_tc_high);
  assign tc_oe     = cfg_tc_drive;
  assign bus_write = cfg_write;
  assign bus_size  = cfg_word;

endmodule

// File: rtl/xhs_dma_chan_chk.sv
module xhs_dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_edge,
  input logic              cfg_ack_high,
  input logic              cfg_tc_drive,
  input logic              cfg_tc_high,
  input logic              dreq,
  input logic              start,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dack,
  input logic              tc_out,
  input logic              tc_oe,
  input logic              irq,
  input logic              stat_limit,
  input logic              stat_eot,
  input logic              req_hit,
  input logic              dack_on,
  input logic              blk_end
);

  // R5: acknowledge never overlaps an outstanding bus request
  assert_bus_dack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && (dack == cfg_ack_high)));

  // R4: request and address held until granted
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> $stable(bus_addr));

  // R2: an accepted request never arrives while an access is pending
  assert_no_hit_in_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> !bus_req);

  // R3: in edge mode the pin moved in the cycle it was accepted
  assert_edge_moved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && cfg_edge) |-> (dreq != $past(dreq)));

  // R7: terminal count only inside an acknowledge window, pin floats in input mode
  assert_tc_with_dack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_oe && (tc_out == cfg_tc_high)) |-> (dack == cfg_ack_high));
  assert_tc_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tc_drive |-> !tc_oe);

  // R10: single-cycle interrupt right after a strobe
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dack_on));

  // R9: status moves only at block end or start
  assert_stat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_end || start) |=> $stable({stat_limit, stat_eot}));

endmodule

bind xhs_dma_chan xhs_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_edge     (cfg_edge),
  .cfg_ack_high (cfg_ack_high),
  .cfg_tc_drive (cfg_tc_drive),
  .cfg_tc_high  (cfg_tc_high),
  .dreq         (dreq),
  .start        (start),
  .bus_req      (bus_req),
  .bus_gnt      (bus_gnt),
  .bus_addr     (bus_addr),
  .dack         (dack),
  .tc_out       (tc_out),
  .tc_oe        (tc_oe),
  .irq          (irq),
  .stat_limit   (stat_limit),
  .stat_eot     (stat_eot),
  .req_hit      (req_hit),
  .dack_on      (dack_on),
  .blk_end      (blk_end)
);

// File: tb/xhs_dma_chan_bench.sv
`timescale 1ns/1ps
module xhs_dma_chan_bench;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int WAIT_W = 4;

  // wd word, wr write, ws wait states, cnt bytes, edg edge mode,
  // rqh/akh/tcd/tch polarities and tc direction, eat deot on access n,
  // hld request held for whole block, nx accesses, lx/ex status expected
  typedef struct packed {
    int wd; int wr; int ws; int cnt; int edg; int rqh; int akh;
    int tcd; int tch; int eat; int hld; int nx; int lx; int ex;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{0,1,0, 4,0,1,1,1,1,0,0,4,1,0},
    '{1,0,2,10,1,0,0,1,0,0,0,3,1,0},
    '{0,1,1, 6,0,1,1,0,1,2,0,2,0,1},
    '{1,0,0, 8,0,0,1,1,1,0,1,2,1,0},
    '{0,0,3, 3,1,1,0,0,0,3,0,3,1,1},
    '{0,1,0, 1,0,1,1,1,1,0,1,1,1,0},
    '{1,1,1, 5,0,1,1,0,1,0,1,2,1,0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_edge = 1'b0, cfg_req_high = 1'b1, cfg_ack_high = 1'b1;
  logic cfg_tc_drive = 1'b0, cfg_tc_high = 1'b1, cfg_word = 1'b0;
  logic cfg_write = 1'b0, cfg_rollover = 1'b0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic desc_we = 1'b0, desc_idx = 1'b0;
  logic [ADDR_W-1:0] desc_addr = '0;
  logic [CNT_W-1:0]  desc_cnt = '0;
  logic start = 1'b0, dreq = 1'b0, deot_in = 1'b0, bus_gnt = 1'b0;
  logic dack, tc_out, tc_oe, bus_req, bus_write, bus_size, irq;
  logic stat_limit, stat_eot, active_desc;
  logic [ADDR_W-1:0] bus_addr;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  xhs_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_xhs_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_edge(cfg_edge), .cfg_req_high(cfg_req_high),
    .cfg_ack_high(cfg_ack_high), .cfg_tc_drive(cfg_tc_drive), .cfg_tc_high(cfg_tc_high),
    .cfg_word(cfg_word), .cfg_write(cfg_write), .cfg_rollover(cfg_rollover),
    .cfg_wait(cfg_wait), .desc_we(desc_we), .desc_idx(desc_idx), .desc_addr(desc_addr),
    .desc_cnt(desc_cnt), .start(start), .dreq(dreq), .deot_in(deot_in), .bus_gnt(bus_gnt),
    .dack(dack), .tc_out(tc_out), .tc_oe(tc_oe), .bus_req(bus_req), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .irq(irq), .stat_limit(stat_limit),
    .stat_eot(stat_eot), .active_desc(active_desc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ack_on();
    return dack === cfg_ack_high;
  endfunction

  task automatic set_cfg(input vec_t v);
    cfg_word     = 1'(v.wd);
    cfg_write    = 1'(v.wr);
    cfg_wait     = WAIT_W'(v.ws);
    cfg_edge     = 1'(v.edg);
    cfg_req_high = 1'(v.rqh);
    cfg_ack_high = 1'(v.akh);
    cfg_tc_drive = 1'(v.tcd);
    cfg_tc_high  = 1'(v.tch);
    dreq         = ~1'(v.rqh);
    deot_in      = ~1'(v.tch);
  endtask

  task automatic put_desc(input bit idx, input int addr, input int cnt);
    desc_we = 1'b1; desc_idx = idx;
    desc_addr = ADDR_W'(addr); desc_cnt = CNT_W'(cnt);
    @(negedge clk);
    desc_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // One access as seen by the peripheral and the bus.
  task automatic do_xfer(input vec_t v, input int i, input int base);
    int step = v.wd != 0 ? 4 : 1;
    int guard = 0;
    int n = 0;
    bit fin = (i == v.nx);
    if (v.hld == 0) begin
      dreq = 1'(v.rqh);
      deot_in = (v.eat == i) ? 1'(v.tch) : ~1'(v.tch);
    end
    while (bus_req !== 1'b1 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(bus_req === 1'b1, "R2 request reaches bus", bus_req, 1);
    chk(bus_addr == ADDR_W'(base + (i - 1) * step), "R4 address", bus_addr, base + (i - 1) * step);
    chk(bus_size == 1'(v.wd), "R4 size", bus_size, v.wd);
    chk(bus_write == 1'(v.wr), "R4 direction", bus_write, v.wr);
    if (v.hld == 0) begin
      dreq = ~1'(v.rqh);
      deot_in = ~1'(v.tch);
    end
    for (int d = 0; d < i % 2; d++) begin
      @(negedge clk);
      chk(bus_req === 1'b1 && !ack_on(), "R4 held until grant", bus_req, 1);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    guard = 0;
    while (ack_on() && guard < 64) begin
      n++;
      if (v.tcd != 0)
        chk(tc_oe === 1'b1 && ((tc_out === 1'(v.tch)) == fin), "R7 terminal count", tc_out, fin);
      else
        chk(tc_oe === 1'b0, "R7 pin released", tc_oe, 0);
      @(negedge clk);
      guard++;
    end
    chk(n == v.ws + 1, "R5 strobe length", n, v.ws + 1);
    chk(irq === fin, "R10 irq timing", irq, fin);
    if (v.hld != 0 && v.edg == 0 && !fin)
      chk(bus_req === 1'b1, "R2 release-cycle sample", bus_req, 1);
  endtask

  task automatic run_vec(input vec_t v, input int base, input int pre_idle);
    cfg_rollover = 1'b0;
    set_cfg(v);
    put_desc(1'b0, base, v.cnt);
    if (v.hld != 0) dreq = 1'(v.rqh);
    pulse_start();
    for (int k = 0; k < pre_idle; k++) begin
      chk(bus_req === 1'b0, "R2 no request no access", bus_req, 0);
      @(negedge clk);
    end
    for (int i = 1; i <= v.nx; i++) do_xfer(v, i, base);
    dreq = ~1'(v.rqh);
    chk(stat_limit === 1'(v.lx), "R9 count status", stat_limit, v.lx);
    chk(stat_eot === 1'(v.ex), "R9 end-of-block status", stat_eot, v.ex);
    dreq = 1'(v.rqh);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_req === 1'b0, "R6 R8 nothing after final access", bus_req, 0);
    end
    dreq = ~1'(v.rqh);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    vec_t ve;
    vec_t vr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(bus_req === 1'b0, "R1 bus_req", bus_req, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(dack === 1'b0, "R1 dack inactive", dack, 0);
    chk(stat_limit === 1'b0 && stat_eot === 1'b0, "R1 status", {stat_limit, stat_eot}, 0);
    chk(active_desc === 1'b0, "R1 active_desc", active_desc, 0);

    // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 across polarities and widths
    for (int k = 0; k < NV; k++) run_vec(VT[k], 32'h1000 * (k + 1), (k == 0) ? 6 : 0);

    // R3: a held request in edge mode starts only one access
    ve = '{0,0,1,2,1,1,1,1,1,0,1,2,1,0};
    set_cfg(ve);
    put_desc(1'b0, 32'h80, 2);
    pulse_start();
    dreq = 1'b1;
    do_xfer(ve, 1, 32'h80);
    for (int k = 0; k < 10; k++) begin
      chk(bus_req === 1'b0, "R3 held edge request ignored", bus_req, 0);
      @(negedge clk);
    end
    dreq = 1'b0;
    @(negedge clk);
    dreq = 1'b1;
    do_xfer(ve, 2, 32'h80);
    dreq = 1'b0;
    chk(stat_limit === 1'b1, "R3 block finished", stat_limit, 1);
    @(negedge clk);

    // R11: rollover to the other descriptor, then stop without it
    vr = '{0,1,0,2,0,1,1,1,1,0,0,2,1,0};
    set_cfg(vr);
    put_desc(1'b0, 32'h100, 2);
    put_desc(1'b1, 32'h200, 1);
    cfg_rollover = 1'b1;
    pulse_start();
    do_xfer(vr, 1, 32'h100);
    do_xfer(vr, 2, 32'h100);
    chk(active_desc === 1'b1, "R11 switched descriptor", active_desc, 1);
    cfg_rollover = 1'b0;
    vr.nx = 1;
    do_xfer(vr, 1, 32'h200);
    chk(active_desc === 1'b1, "R11 no switch when disabled", active_desc, 1);
    dreq = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_req === 1'b0, "R11 idle after block", bus_req, 0);
    end
    dreq = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule